// File: doc/BRIEF.md
# Sliding-Window Mean-Absolute-Deviation Correlator

This block matches a streaming signal against a fixed pulse shape. Every accepted sample enters a window that holds the N = 64 most recent samples, dropping the oldest one. Once the window has been full, each new sample produces one similarity score between the window and a stored template. The score works like a correlation coefficient. The window mean is removed from every sample, each deviation is multiplied by its template coefficient, and the sum of those products is divided by a dispersion figure. That figure comes from the sum of absolute deviations, so the datapath needs no squaring and no square root.

The template is loaded as 64 signed Q1.14 coefficients through a write port. The coefficients are prepared off-chip: they are the template's deviations scaled to unit Euclidean norm. The dispersion figure is the absolute-deviation sum divided by √N (a shift by 3 for N = 64). With this scaling, a window that is an exact scaled and shifted copy of a two-level template scores exactly +1.0. Scores outside ±1.0 are clipped. The score does not depend on the input's DC offset or amplitude, only on its shape.

Samples enter through a valid/ready handshake, and scores leave through a second one. The block processes one window at a time. It accumulates one window position per clock, then runs a sequential divide, and holds off new input until the score has been taken.

Top module: `mad_corr_top`

## Requirements
- R1: Coefficient index i is paired with the i-th oldest sample of the window: index 0 goes with the oldest sample and index 63 with the newest (the sample just accepted).
- R2: After reset, in_ready is 1 and out_valid is 0. The first 64 accepted samples produce no score, and every later accepted sample produces exactly one score.
- R3: For a window with sum S, mean m = floor(S/64), P = Σ (x_i − m)·c_i and D = floor(Σ |x_i − m| / 8). The score is P/D truncated toward zero, returned as a signed 16-bit Q1.14 value (16384 means +1.0). It may differ from this value by at most 2 LSB.
- R4: A quotient whose magnitude exceeds 16384 is clipped to +16384 or −16384, keeping its sign. The clip applies whether the raw quotient fits in 16 bits or not.
- R5: When D is 0, the score is exactly 0. This covers a flat window and a window whose absolute-deviation sum is below 8.
- R6: in_ready is 0 from the clock edge that accepts a score-producing sample until that score has been taken, so no sample is accepted while a score is pending.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R8: A coefficient written at a clock edge with coef_we high (address coef_addr, value coef_data) is used for every sample accepted after that edge.
- R9: Take a window equal to off + A·s_i, where s_i is ±1 with 32 entries of each sign, and coefficients 2048·s_i. The score is exactly +16384 for A > 0 and −16384 for A < 0.
- R10: Adding the same integer to every input sample leaves every score unchanged, as long as the samples stay inside the 14-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the window, the template and the control state |
| in_valid | input | 1 | A sample is offered on in_data |
| in_ready | output | 1 | The block can accept a sample this cycle |
| in_data | input | 14 | Signed input sample |
| coef_we | input | 1 | Write strobe for the template table |
| coef_addr | input | 6 | Template index to write (0 = oldest window position) |
| coef_data | input | 16 | Signed Q1.14 coefficient value |
| out_valid | output | 1 | A score is available on out_data |
| out_ready | input | 1 | The consumer takes the score this cycle |
| out_data | output | 16 | Signed Q1.14 score, clipped to ±16384 |

## Verification
The bench checks that no score appears before the 65th sample. A design that counted one sample short would produce an extra score at the 64th input.

It drives a ramp against a template weighted only at its two ends. If coefficients were paired with the window in reversed order, the sign of the score would flip.

It aims two-level inputs at two-level templates so the quotient lands exactly on 16384. It also scales the same template so the quotient lands on 32768 or 65536. This exposes a clip that wraps instead of saturating, and a pre-check that misses the case where the numerator equals the divisor shifted by 16.

Two further cases cover the zero-divisor path. One is a flat window. The other has a single deviation of 3, where the product sum is nonzero but D is zero; a design that skipped the D = 0 check would return a garbage quotient there. The bench also holds out_ready low to catch a score that changes or a sample that slips in under back-pressure. Finally, it replays one stream at two DC offsets, which exposes any rounding error in the mean.

// File: rtl/mad_corr_pkg.sv
package mad_corr_pkg;

    // Control sequence of the correlator core
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAN,
        ST_ACC,
        ST_LAUNCH,
        ST_DIV,
        ST_OUT
    } corr_state_e;

endpackage

// File: rtl/mad_window.sv
// Circular sample store with a running window sum.
module mad_window #(
    parameter int LOG2N = 6,
    parameter int DW    = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 din,
    input  logic [LOG2N-1:0]              rd_addr,
    output logic [DW-1:0]                 rd_data,
    output logic [LOG2N-1:0]              oldest,
    output logic signed [DW+LOG2N-1:0]    sum,
    output logic                          full
);
    localparam int N    = 1 << LOG2N;
    localparam int SUMW = DW + LOG2N;

    typedef struct packed {
        logic [N-1:0][DW-1:0]    mem;
        logic [LOG2N-1:0]        wp;
        logic [LOG2N:0]          fill;
        logic signed [SUMW-1:0]  acc;
    } win_t;

    win_t win_q, win_d;
    logic signed [SUMW-1:0] new_ext;
    logic signed [SUMW-1:0] old_ext;

    assign full    = (win_q.fill == (LOG2N+1)'(N));
    assign rd_data = win_q.mem[rd_addr];
    assign oldest  = win_q.wp;
    assign sum     = win_q.acc;

    always_comb begin
        new_ext = SUMW'($signed(din));
        old_ext = SUMW'($signed(win_q.mem[win_q.wp]));
        win_d   = win_q;
        if (push) begin
            // the evicted slot is zero until the window first fills
            win_d.mem[win_q.wp] = din;
            win_d.acc           = win_q.acc + new_ext - old_ext;
            win_d.wp            = win_q.wp + 1'b1;
            if (!full) begin
                win_d.fill = win_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/mad_coef_table.sv
// Register table of template coefficients, one write and one read port.
module mad_coef_table #(
    parameter int LOG2N = 6,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LOG2N-1:0] waddr,
    input  logic [CW-1:0]    wdata,
    input  logic [LOG2N-1:0] raddr,
    output logic [CW-1:0]    rdata
);
    localparam int N = 1 << LOG2N;

    typedef struct packed {
        logic [N-1:0][CW-1:0] mem;
    } tab_t;

    tab_t tab_q, tab_d;

    assign rdata = tab_q.mem[raddr];

    always_comb begin
        tab_d = tab_q;
        if (we) begin
            tab_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end
endmodule

// File: rtl/mad_divider.sv
// Sequential restoring divider on magnitudes, one quotient bit per cycle,
// with a clip to +/-QMAX and a zero result for a zero divisor.
module mad_divider #(
    parameter int NUMW = 37,
    parameter int DENW = 18,
    parameter int QW   = 16,
    parameter int QMAX = 16384
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NUMW-1:0]       num,
    input  logic [DENW-1:0]       den,
    input  logic                  neg,
    output logic                  done,
    output logic signed [QW-1:0]  quo
);
    localparam int CNTW = $clog2(QW);

    typedef struct packed {
        logic             busy;
        logic [CNTW-1:0]  cnt;
        logic [NUMW-1:0]  rem;
        logic [NUMW-1:0]  dv;
        logic [QW-1:0]    q;
        logic             sat;
        logic             neg;
        logic             done;
        logic [QW-1:0]    res;
    } div_t;

    div_t div_q, div_d;
    logic [QW-1:0] q_fin;
    logic [QW-1:0] mag;

    assign done = div_q.done;
    assign quo  = $signed(div_q.res);

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        q_fin      = '0;
        mag        = '0;
        if (start) begin
            div_d.busy = (den != '0);
            div_d.done = (den == '0);
            div_d.res  = '0;
            div_d.rem  = num;
            div_d.dv   = NUMW'(den) << (QW - 1);
            div_d.q    = '0;
            div_d.cnt  = CNTW'(QW - 1);
            div_d.neg  = neg;
            // a quotient of 2^QW or more cannot be formed: clip it
            div_d.sat  = ({1'b0, num} >= ((NUMW+1)'(den) << QW));
        end else if (div_q.busy) begin
            q_fin = div_q.q;
            if (div_q.rem >= div_q.dv) begin
                div_d.rem         = div_q.rem - div_q.dv;
                q_fin[div_q.cnt]  = 1'b1;
            end
            div_d.q   = q_fin;
            div_d.dv  = div_q.dv >> 1;
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == '0) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
                mag        = (div_q.sat || (q_fin > QW'(QMAX))) ? QW'(QMAX) : q_fin;
                div_d.res  = div_q.neg ? (~mag + 1'b1) : mag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/mad_corr_top.sv
// Streaming template correlator normalised by absolute deviation.
module mad_corr_top
    import mad_corr_pkg::*;
#(
    parameter int LOG2N = 6,
    parameter int DW    = 14,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    input  logic             coef_we,
    input  logic [LOG2N-1:0] coef_addr,
    input  logic [CW-1:0]    coef_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CW-1:0]    out_data
);
    localparam int N     = 1 << LOG2N;
    localparam int SUMW  = DW + LOG2N;
    localparam int DEVW  = DW + 1;
    localparam int PRODW = DEVW + CW;
    localparam int ACCW  = PRODW + LOG2N;
    localparam int ABSW  = DEVW + LOG2N;
    localparam int DSH   = LOG2N / 2;
    localparam int DENW  = ABSW - DSH;
    localparam int QMAX  = 1 << (CW - 2);
    localparam logic [LOG2N-1:0] K_LAST = LOG2N'(N - 1);

    typedef struct packed {
        corr_state_e             st;
        logic [LOG2N-1:0]        k;
        logic signed [DW-1:0]    mean;
        logic signed [ACCW-1:0]  acc;
        logic [ABSW-1:0]         abss;
        logic [CW-1:0]           res;
    } core_t;

    core_t core_q, core_d;

    logic                    push;
    logic                    win_full;
    logic [LOG2N-1:0]        win_oldest;
    logic signed [SUMW-1:0]  win_sum;
    logic signed [SUMW-1:0]  sum_sh;
    logic [DW-1:0]           win_rd;
    logic [CW-1:0]           coef_rd;
    logic signed [DEVW-1:0]  dev;
    logic [DEVW-1:0]         absdev;
    logic signed [PRODW-1:0] prod;
    logic                    div_start;
    logic [ACCW-1:0]         div_num;
    logic [DENW-1:0]         div_den;
    logic                    div_neg;
    logic                    div_done;
    logic signed [CW-1:0]    div_quo;

    assign in_ready  = (core_q.st == ST_IDLE);
    assign push      = in_valid && in_ready;
    assign out_valid = (core_q.st == ST_OUT);
    assign out_data  = core_q.res;

    mad_window #(.LOG2N(LOG2N), .DW(DW)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .din     (in_data),
        .rd_addr (win_oldest + core_q.k),
        .rd_data (win_rd),
        .oldest  (win_oldest),
        .sum     (win_sum),
        .full    (win_full)
    );

    mad_coef_table #(.LOG2N(LOG2N), .CW(CW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (core_q.k),
        .rdata (coef_rd)
    );

    mad_divider #(.NUMW(ACCW), .DENW(DENW), .QW(CW), .QMAX(QMAX)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .neg   (div_neg),
        .done  (div_done),
        .quo   (div_quo)
    );

    // datapath of one accumulation step
    always_comb begin
        sum_sh  = win_sum >>> LOG2N;
        dev     = DEVW'($signed(win_rd)) - DEVW'(core_q.mean);
        absdev  = dev[DEVW-1] ? DEVW'(-dev) : DEVW'(dev);
        prod    = dev * $signed(coef_rd);
        div_neg = core_q.acc[ACCW-1];
        div_num = core_q.acc[ACCW-1] ? ACCW'(-core_q.acc) : ACCW'(core_q.acc);
        div_den = DENW'(core_q.abss >> DSH);
    end

    // control sequence
    always_comb begin
        core_d    = core_q;
        div_start = 1'b0;
        case (core_q.st)
            ST_IDLE: begin
                if (push && win_full) begin
                    core_d.st = ST_MEAN;
                end
            end
            ST_MEAN: begin
                core_d.mean = sum_sh[DW-1:0];
                core_d.acc  = '0;
                core_d.abss = '0;
                core_d.k    = '0;
                core_d.st   = ST_ACC;
            end
            ST_ACC: begin
                core_d.acc  = core_q.acc + ACCW'(prod);
                core_d.abss = core_q.abss + ABSW'(absdev);
                core_d.k    = core_q.k + 1'b1;
                if (core_q.k == K_LAST) begin
                    core_d.st = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                div_start = 1'b1;
                core_d.st = ST_DIV;
            end
            ST_DIV: begin
                if (div_done) begin
                    core_d.res = div_quo;
                    core_d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    core_d.st = ST_IDLE;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= ST_IDLE;
        end else begin
            core_q <= core_d;
        end
    end
endmodule

// File: rtl/mad_corr_chk.sv
// Protocol and range properties of the correlator ports.
module mad_corr_chk #(
    parameter int LOG2N = 6,
    parameter int CW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [CW-1:0] out_data
);
    localparam int N   = 1 << LOG2N;
    localparam int ONE = 1 << (CW - 2);
    localparam logic signed [CW-1:0] S_POS = CW'(ONE);
    localparam logic signed [CW-1:0] S_NEG = -CW'(ONE);

    logic [LOG2N+1:0]      seen_q;
    logic signed [CW-1:0]  od;

    assign od = out_data;

    // accepted samples, held at N+1 once past the fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid && in_ready && (seen_q <= (LOG2N+2)'(N))) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    p_no_early_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q > (LOG2N+2)'(N)));

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (seen_q >= (LOG2N+2)'(N))) |=> !in_ready);

    p_no_accept_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_score_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_clip_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((od <= S_POS) && (od >= S_NEG)));
endmodule

bind mad_corr_top mad_corr_chk #(.LOG2N(LOG2N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_mad_corr_top.sv
module sim_mad_corr_top;
    localparam int LOG2N = 6;
    localparam int NW    = 64;
    localparam int DW    = 14;
    localparam int CW    = 16;
    localparam int ONE   = 16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [DW-1:0]    in_data = '0;
    logic             coef_we = 1'b0;
    logic [LOG2N-1:0] coef_addr = '0;
    logic [CW-1:0]    coef_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [CW-1:0]    out_data;

    int errs = 0;
    int checks = 0;
    int smp[0:4095];
    int nsmp = 0;
    int cf[0:NW-1];
    int last_out = 0;
    int keep[0:31];
    logic [31:0] seed = 32'h1234_5678;

    mad_corr_top #(.LOG2N(LOG2N), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic int rnd(int span);
        int t;
        seed = seed * 32'd1103515245 + 32'd12345;
        t = int'(seed[30:16]);
        return (t % span) - span / 2;
    endfunction

    function automatic int sq(int i);
        return (((i * 37) % 64) < 32) ? 1 : -1;
    endfunction

    // expected score for the window that ends at sample j
    function automatic int ref_out(int j);
        longint s = 0;
        longint m, d, p = 0, a = 0, den, mag;
        for (int k = 0; k < NW; k++) s += smp[j-NW+1+k];
        m = s >>> 6;
        for (int k = 0; k < NW; k++) begin
            d = smp[j-NW+1+k] - m;
            p += d * cf[k];
            a += (d < 0) ? -d : d;
        end
        den = a >>> 3;
        if (den == 0) return 0;
        mag = ((p < 0) ? -p : p) / den;
        if (mag > ONE) mag = ONE;
        return int'((p < 0) ? -mag : mag);
    endfunction

    task automatic check(input string tag, input int act, input int exp, input int tol);
        int diff;
        checks++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        coef_we = 1'b0;
        out_ready = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nsmp = 0;
        for (int i = 0; i < NW; i++) cf[i] = 0;
        @(negedge clk);
    endtask

    task automatic load_coef(input int idx, input int val);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = LOG2N'(idx);
        coef_data = CW'(val);
        @(posedge clk);
        #1 coef_we = 1'b0;
        cf[idx] = val;
    endtask

    task automatic load_tri();
        real sh[NW];
        real mu, nrm;
        int v;
        mu = 0.0;
        nrm = 0.0;
        for (int i = 0; i < NW; i++) begin
            sh[i] = (i < 20) ? i * 100.0 : (63 - i) * 45.0;
            mu += sh[i];
        end
        mu = mu / NW;
        for (int i = 0; i < NW; i++) nrm += (sh[i] - mu) * (sh[i] - mu);
        nrm = $sqrt(nrm);
        for (int i = 0; i < NW; i++) begin
            v = $rtoi((sh[i] - mu) / nrm * ONE + (((sh[i] - mu) >= 0.0) ? 0.5 : -0.5));
            load_coef(i, v);
        end
    endtask

    task automatic load_sq(input int scale);
        for (int i = 0; i < NW; i++) load_coef(i, scale * sq(i));
    endtask

    task automatic push(input int x);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data = DW'(x);
        @(posedge clk);
        #1 in_valid = 1'b0;
        smp[nsmp] = x;
        nsmp++;
    endtask

    task automatic get_out();
        int w = 0;
        @(negedge clk);
        while (!out_valid && w < 400) begin
            @(negedge clk);
            w++;
        end
        if (!out_valid) begin
            checks++;
            errs++;
            $display("FAIL R2: no score, actual=none expected=score");
            last_out = 99999;
        end else begin
            last_out = $signed(out_data);
            @(posedge clk);
            #1;
        end
    endtask

    // push one sample; check fill silence or the score against the model
    task automatic push_chk(input int x, input string tag);
        push(x);
        if (nsmp > NW) begin
            get_out();
            check(tag, last_out, ref_out(nsmp - 1), 2);
        end else begin
            @(negedge clk);
            check("R2 no score during fill", int'(out_valid), 0, 0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 in_ready after reset", int'(in_ready), 1, 0);
        check("R2 out_valid after reset", int'(out_valid), 0, 0);
    endtask

    // fill, first score, random stream, live coefficient change
    task automatic t_fill_stream();
        do_reset();
        load_tri();
        for (int i = 0; i < NW; i++) push_chk(rnd(6000), "R2");
        push_chk(rnd(6000), "R3 first score");
        for (int i = 0; i < 30; i++) push_chk(rnd(12000), "R3 stream");
        load_coef(5, cf[5] + 3000);
        load_coef(60, -5000);
        for (int i = 0; i < 6; i++) push_chk(rnd(12000), "R8 new coefficients");
    endtask

    // ramp against a template weighted only at both ends
    task automatic t_order();
        do_reset();
        load_coef(0, 8192);
        load_coef(NW - 1, -8192);
        for (int i = 0; i < NW + 6; i++) push_chk(i * 60, "R1 order");
        check("R1 score sign negative", (last_out < 0) ? 1 : 0, 1, 0);
    endtask

    task automatic t_flat();
        do_reset();
        load_tri();
        for (int i = 0; i < NW + 3; i++) push_chk(1234, "R5 flat");
        check("R5 flat window", last_out, 0, 0);
        push_chk(1237, "R5 tiny spread");
        check("R5 tiny spread", last_out, 0, 0);
    endtask

    task automatic t_match();
        do_reset();
        load_sq(2048);
        for (int i = 0; i < 2 * NW; i++) push_chk(500 + 3000 * sq(i % NW), "R3 match run");
        check("R9 aligned copy", last_out, ONE, 0);
        for (int i = 0; i < NW; i++) push_chk(-1000 + 700 * sq(i), "R3 match run");
        check("R10 other offset and amplitude", last_out, ONE, 0);
        for (int i = 0; i < NW; i++) push_chk(-2000 * sq(i), "R3 match run");
        check("R9 inverted copy", last_out, -ONE, 0);
    endtask

    task automatic t_offset();
        int base[0:NW+19];
        for (int i = 0; i < NW + 20; i++) base[i] = rnd(4000);
        do_reset();
        load_tri();
        for (int i = 0; i < NW + 20; i++) begin
            push_chk(base[i] + 3000, "R3 offset run");
            if (i >= NW) keep[i-NW] = last_out;
        end
        do_reset();
        load_tri();
        for (int i = 0; i < NW + 20; i++) begin
            push_chk(base[i] - 2500, "R3 offset run");
            if (i >= NW) check("R10 offset invariance", last_out, keep[i-NW], 0);
        end
    endtask

    task automatic t_clip();
        do_reset();
        load_sq(8192);
        for (int i = 0; i < 2 * NW; i++) push_chk(1000 * sq(i % NW), "R4 clip run");
        check("R4 clip at 2^16 quotient", last_out, ONE, 0);
        load_sq(4096);
        for (int i = 0; i < NW; i++) push_chk(-1000 * sq(i), "R4 clip run");
        check("R4 clip of negative 2^15 quotient", last_out, -ONE, 0);
    endtask

    task automatic t_backpressure();
        int v;
        int w = 0;
        do_reset();
        load_tri();
        for (int i = 0; i < NW; i++) push_chk(rnd(8000), "R2");
        out_ready = 1'b0;
        push(rnd(8000));
        @(negedge clk);
        while (!out_valid && w < 400) begin
            @(negedge clk);
            w++;
        end
        v = $signed(out_data);
        check("R3 held score", v, ref_out(nsmp - 1), 2);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R7 valid held", int'(out_valid), 1, 0);
            check("R7 data stable", $signed(out_data), v, 0);
            check("R6 ready low while pending", int'(in_ready), 0, 0);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        check("R7 score taken", int'(out_valid), 0, 0);
        check("R6 ready back", int'(in_ready), 1, 0);
        push_chk(rnd(8000), "R3 after back-pressure");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_stream();
        t_order();
        t_flat();
        t_match();
        t_offset();
        t_clip();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule